// File: doc/BRIEF.md
# Channel Scan Sequencer with Burst Mode

This block chooses the input channel for every conversion of a differential acquisition front end. Software writes one 8-bit word that gives a first channel and a last channel. Each conversion then takes the current channel and moves the cursor one step, wrapping from the last channel back to the first. The channel shown on `next_chan` is always the one the next conversion will use, not the one just converted. Each write of the scan word reloads the cursor and sends a one-cycle clear pulse to the sample buffer that follows the converter.

A second 8-bit word enables burst mode and sets a burst length. When burst mode is on, one trigger starts a run of back-to-back conversions. The first conversion is issued at once and the rest follow at the full converter rate, paced by an internal divider of the system clock (`TICK_DIV` cycles per conversion). Triggers that arrive while a run is in progress are dropped. The spacing between runs is set by whatever drives `trig`.

Top module: `chscan_seq`

## Requirements
- R1: After reset, `next_chan` is 0 and `conv_go`, `fifo_clr` and `burst_busy` are 0. The scan range is channel 0 only, and burst mode is off with length 0.
- R2: A write with `cfg_sel`=0 loads the scan word. Bits [2:0] give the first channel and bits [6:4] give the last channel. Bits 3 and 7 are ignored. In the cycle after the write, `next_chan` equals the new first channel.
- R3: `fifo_clr` is high for exactly the one cycle after each scan-word write, and at no other time.
- R4: With burst mode inactive, a `trig` pulse makes `conv_go` high in the next cycle. In that cycle `conv_chan` equals the value `next_chan` had when the trigger was sampled, and `next_chan` has moved to the following channel.
- R5: After the last channel, the cursor returns to the first channel. If the first channel is greater than the last, the cursor counts up through 7, wraps to 0 and continues up to the last channel. Examples: 0x20 gives 0,1,2,0; 0x11 gives 1,1; 0x65 gives 5,6,5; 0x16 gives 6,7,0,1,6.
- R6: A write with `cfg_sel`=1 loads the burst word. Bits [3:0] are the burst length and bit 4 enables burst mode. The new value applies to triggers sampled after the write.
- R7: With burst mode enabled and a length L of 2 or more, an accepted trigger issues L conversions. The first comes one cycle after the trigger and the next ones every `TICK_DIV` cycles after that. `burst_busy` is high from the cycle after the trigger until the last conversion.
- R8: With a length of 0 or 1, or with burst mode disabled, a trigger issues exactly one conversion and `burst_busy` stays low.
- R9: A `trig` sampled while `burst_busy` is high is ignored. The run keeps its count and timing, and no extra conversion appears.
- R10: A `trig` in the same cycle as a scan-word write is dropped. A burst conversion that falls in the same cycle as a scan-word write is still issued, using the channel from before the write. The cursor then reloads to the new first channel, and the run continues from there.
- R11: `burst_busy` falls in the same cycle in which `conv_go` shows the final conversion of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = scan word, 1 = burst word |
| cfg_wdata | input | 8 | Configuration write data |
| trig | input | 1 | Conversion trigger / burst start event |
| conv_go | output | 1 | One-cycle conversion strobe to the converter |
| conv_chan | output | CH_W | Channel for the strobed conversion |
| next_chan | output | CH_W | Channel the next conversion will use |
| fifo_clr | output | 1 | One-cycle sample buffer clear after a scan write |
| burst_busy | output | 1 | A burst run is in progress |

## Verification
The hardest case to reach is a scan-word write that lands in the very cycle in which a burst's pacing divider expires. From the ports this moment can only be found by counting cycles from the trigger. The stimulus starts a maximum-length burst and places the write exactly `TICK_DIV` cycles after the trigger, so the old-channel conversion and the cursor reload happen together. Triggers during a run, a trigger on the same cycle as a write, and reversed ranges that wrap through channel 7 are also driven. Every output is compared against the reference model on every cycle.

// File: rtl/chscan_pkg.sv
package chscan_pkg;

   // Selector for the two configuration words.
   typedef enum logic {
      SEL_SCAN  = 1'b0,
      SEL_BURST = 1'b1
   } cfg_sel_e;

   typedef logic [3:0] nib_t;

   // Scan word: upper nibble holds the last channel, lower the first.
   typedef struct packed {
      nib_t last;
      nib_t first;
   } scan_word_t;

   // Burst word: bit 4 enables burst mode, low nibble is the length.
   typedef struct packed {
      logic [2:0] rsvd;
      logic       enable;
      nib_t       length;
   } burst_word_t;

endpackage

// File: rtl/chscan_pacer.sv
module chscan_pacer #(
   parameter int DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("chscan_pacer: DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/chscan_cursor.sv
module chscan_cursor #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic [CH_W-1:0] first,
   input  logic [CH_W-1:0] last,
   output logic [CH_W-1:0] cur
);
   logic [CH_W-1:0] cur_q;
   logic [CH_W-1:0] inc;

   // Successor of the cursor inside the channel space.
   if ((1 << CH_W) == NUM_CH) begin : g_pow2
      assign inc = cur_q + 1'b1;
   end else begin : g_nonpow2
      assign inc = (cur_q == CH_W'(NUM_CH - 1)) ? '0 : cur_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else begin
         if (step) begin
            cur_q <= (cur_q == last) ? first : inc;
         end
         if (load) begin
            cur_q <= first;
         end
      end
   end

   assign cur = cur_q;
endmodule

// File: rtl/chscan_burst.sv
module chscan_burst #(
   parameter int LEN_W    = 4,
   parameter int TICK_DIV = 125
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             burst_mode,
   input  logic [LEN_W-1:0] len,
   output logic             issue,
   output logic             busy
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic             busy_q;
   logic [LEN_W-1:0] left_q;
   logic             accept;
   logic             tick;
   logic             multi;

   assign accept = start && !busy_q;
   assign multi  = burst_mode && (len > ONE);
   assign issue  = accept || tick;

   chscan_pacer #(.DIV(TICK_DIV)) i_pacer (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (accept),
      .run  (busy_q),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (accept && multi) begin
         busy_q <= 1'b1;
         left_q <= len - ONE;
      end else if (tick) begin
         left_q <= left_q - ONE;
         if (left_q == ONE) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
endmodule

// File: rtl/chscan_seq.sv
module chscan_seq
   import chscan_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int LEN_W    = 4,
   parameter int TICK_DIV = 125,
   localparam int CH_W    = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic            cfg_sel,
   input  logic [7:0]      cfg_wdata,
   input  logic            trig,
   output logic            conv_go,
   output logic [CH_W-1:0] conv_chan,
   output logic [CH_W-1:0] next_chan,
   output logic            fifo_clr,
   output logic            burst_busy
);
   if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_ch
      $error("chscan_seq: NUM_CH must be within 2..16");
   end
   if (LEN_W < 1 || LEN_W > 4) begin : g_bad_len
      $error("chscan_seq: LEN_W must be within 1..4");
   end

   scan_word_t  scan_w;
   burst_word_t burst_w;
   logic        scan_wr;
   logic        mode_wr;

   assign scan_w  = scan_word_t'(cfg_wdata);
   assign burst_w = burst_word_t'(cfg_wdata);
   assign scan_wr = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_SCAN);
   assign mode_wr = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_BURST);

   logic [CH_W-1:0]  first_q;
   logic [CH_W-1:0]  last_q;
   logic             ben_q;
   logic [LEN_W-1:0] blen_q;
   logic             fifo_clr_q;
   logic             go_q;
   logic [CH_W-1:0]  chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q    <= '0;
         last_q     <= '0;
         ben_q      <= 1'b0;
         blen_q     <= '0;
         fifo_clr_q <= 1'b0;
      end else begin
         fifo_clr_q <= scan_wr;
         if (scan_wr) begin
            first_q <= scan_w.first[CH_W-1:0];
            last_q  <= scan_w.last[CH_W-1:0];
         end
         if (mode_wr) begin
            ben_q  <= burst_w.enable;
            blen_q <= burst_w.length[LEN_W-1:0];
         end
      end
   end

   logic            burst_mode;
   logic            issue;
   logic            busy;
   logic [CH_W-1:0] cur;

   assign burst_mode = ben_q && (blen_q != '0);

   chscan_burst #(.LEN_W(LEN_W), .TICK_DIV(TICK_DIV)) i_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (trig && !scan_wr),
      .burst_mode(burst_mode),
      .len       (blen_q),
      .issue     (issue),
      .busy      (busy)
   );

   chscan_cursor #(.NUM_CH(NUM_CH)) i_cursor (
      .clk  (clk),
      .rst_n(rst_n),
      .load (scan_wr),
      .step (issue),
      .first(scan_wr ? scan_w.first[CH_W-1:0] : first_q),
      .last (last_q),
      .cur  (cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q   <= 1'b0;
         chan_q <= '0;
      end else begin
         go_q <= issue;
         if (issue) begin
            chan_q <= cur;
         end
      end
   end

   // Bits of the configuration words that carry no function.
   logic unused_cfg;
   assign unused_cfg = ^{cfg_wdata[7], cfg_wdata[3], burst_w.rsvd};

   assign conv_go    = go_q;
   assign conv_chan  = chan_q;
   assign next_chan  = cur;
   assign fifo_clr   = fifo_clr_q;
   assign burst_busy = busy;
endmodule

// File: rtl/chscan_seq_chk.sv
module chscan_seq_chk #(
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic            cfg_sel,
   input logic [7:0]      cfg_wdata,
   input logic            trig,
   input logic            conv_go,
   input logic [CH_W-1:0] conv_chan,
   input logic [CH_W-1:0] next_chan,
   input logic            fifo_clr,
   input logic            burst_busy
);
   a_r3_clr_after_scan_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> fifo_clr);

   a_r3_clr_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |-> $past(cfg_we && !cfg_sel));

   a_r2_reload_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> (next_chan == $past(cfg_wdata[CH_W-1:0])));

   a_r4_chan_was_next: assert property (@(posedge clk) disable iff (!rst_n)
      conv_go |-> (conv_chan == $past(next_chan)));

   a_r11_busy_ends_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(burst_busy) |-> conv_go);

   a_r9_no_idle_to_busy_without_trig: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_busy) |-> ($past(trig) && conv_go));
endmodule

bind chscan_seq chscan_seq_chk #(.CH_W(CH_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .trig      (trig),
   .conv_go   (conv_go),
   .conv_chan (conv_chan),
   .next_chan (next_chan),
   .fifo_clr  (fifo_clr),
   .burst_busy(burst_busy)
);

// File: tb/test_chscan_seq.sv
module test_chscan_seq;
   localparam int DIV = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       trig = 1'b0;
   logic       conv_go;
   logic [2:0] conv_chan;
   logic [2:0] next_chan;
   logic       fifo_clr;
   logic       burst_busy;

   always #4 clk = ~clk;

   chscan_seq #(.NUM_CH(8), .LEN_W(4), .TICK_DIV(DIV)) i_chscan_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .trig(trig), .conv_go(conv_go),
      .conv_chan(conv_chan), .next_chan(next_chan), .fifo_clr(fifo_clr),
      .burst_busy(burst_busy)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   // Reference model state.
   int m_first = 0, m_last = 0, m_cur = 0;
   int m_en = 0, m_len = 0;
   int m_busy = 0, m_left = 0, m_phase = 0;
   int m_go = 0, m_chan = 0, m_clr = 0;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input string tag, input string nm, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", tag, cur_req, nm, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R4", "conv_go",    int'(conv_go),    m_go);
      chk("R4", "conv_chan",  int'(conv_chan),  m_chan);
      chk("R2", "next_chan",  int'(next_chan),  m_cur);
      chk("R3", "fifo_clr",   int'(fifo_clr),   m_clr);
      chk("R11", "burst_busy", int'(burst_busy), m_busy);
   endtask

   task automatic m_issue();
      m_go   = 1;
      m_chan = m_cur;
      m_cur  = (m_cur == m_last) ? m_first : (m_cur + 1) % 8;
   endtask

   task automatic model_edge(input bit we, input bit sel, input logic [7:0] wd, input bit tr);
      int old_busy = m_busy;
      bit scan_w   = we && !sel;
      m_go  = 0;
      m_clr = 0;
      if (m_busy != 0) begin
         m_phase++;
         if (m_phase == DIV) begin
            m_phase = 0;
            m_issue();
            m_left--;
            if (m_left == 0) m_busy = 0;
         end
      end
      if (tr && !scan_w && old_busy == 0) begin
         m_issue();
         if (m_en != 0 && m_len > 1) begin
            m_busy  = 1;
            m_left  = m_len - 1;
            m_phase = 0;
         end
      end
      if (scan_w) begin
         m_first = int'(wd[2:0]);
         m_last  = int'(wd[6:4]);
         m_cur   = m_first;
         m_clr   = 1;
      end
      if (we && sel) begin
         m_len = int'(wd[3:0]);
         m_en  = int'(wd[4]);
      end
   endtask

   task automatic step(input bit we, input bit sel, input logic [7:0] wd, input bit tr);
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd; trig = tr;
      @(posedge clk);
      model_edge(we, sel, wd, tr);
      @(negedge clk);
      cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00; trig = 1'b0;
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0);
   endtask

   task automatic scan(input logic [7:0] w);
      step(1, 0, w, 0);
   endtask

   task automatic burst_cfg(input logic [7:0] w);
      step(1, 1, w, 0);
   endtask

   task automatic fire(input int n);
      for (int i = 0; i < n; i++) begin
         step(0, 0, 8'h00, 1);
         idle(1);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      cur_req = "R1";
      compare_all();
      rst_n = 1'b1;
      idle(2);

      cur_req = "R2"; scan(8'h11); fire(3);
      cur_req = "R5"; scan(8'h20); fire(4);
      cur_req = "R5"; scan(8'h65); fire(3);
      cur_req = "R5"; scan(8'h16); fire(5);
      cur_req = "R2"; scan(8'hF9); fire(3);

      cur_req = "R6"; burst_cfg(8'h13); scan(8'h20);
      cur_req = "R7"; step(0, 0, 8'h00, 1); idle(3 * DIV);
      step(0, 0, 8'h00, 1); idle(3 * DIV);

      cur_req = "R9"; scan(8'h70); step(0, 0, 8'h00, 1); idle(3);
      step(0, 0, 8'h00, 1); idle(DIV - 1); step(0, 0, 8'h00, 1); idle(3 * DIV);

      cur_req = "R8"; burst_cfg(8'h10); fire(2);
      burst_cfg(8'h05); fire(2);
      burst_cfg(8'h11); fire(2);

      cur_req = "R10"; step(1, 0, 8'h43, 1); idle(2); fire(2);
      burst_cfg(8'h1F); scan(8'h40);
      step(0, 0, 8'h00, 1); idle(DIV - 1);
      step(1, 0, 8'h52, 0);
      cur_req = "R11"; idle(16 * DIV);

      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end
endmodule